// File: doc/BRIEF.md
# Ethernet Receive Buffer Controller

This block takes Ethernet frames arriving one byte per cycle and stores each accepted frame in one of two on-chip receive buffers of `CAP_BYTES` bytes. A select input, sampled with the first byte of a frame, chooses the buffer. Bytes are written at an offset equal to their position in the frame. A destination filter admits two kinds of frame: group-addressed frames, whose first byte has bit 7 set, and frames whose six destination bytes match the station address.

Each buffer has a 32-bit control word that software owns. Bit 0 is the "frame held" flag, bit 1 is a general flag that is only stored, and bit 3 enables the interrupt. When a frame completes and passes both the filter and the length check, the block sets bit 0 of the chosen buffer. When bit 3 of that buffer is set, the block also pulses that buffer's interrupt line. While bit 0 is set, the buffer is closed: every frame aimed at it is discarded whole. Software reads the frame through the register port and then writes the control word with bit 0 clear to reopen the buffer.

The register address is split into fields. Bit 12 selects the control word (1) or buffer data (0). Bit 11 picks the buffer, which places the two buffers 0x800 apart. Bits 10:0 give the byte offset in the data space.

Top module: `eth_rx_buffer_ctrl`

## Requirements
- R1: After reset, both control words read 0 and both interrupt lines are low.
- R2: A frame is accepted only when bit 7 of its first byte is 1, or when bytes 0..5 equal `station_mac` (byte 0 compared with bits 47:40, down to byte 5 with bits 7:0). Any other frame, including a frame shorter than six bytes with bit 7 of byte 0 clear, leaves the control word unchanged and raises no interrupt.
- R3: `rx_buf_sel` is sampled with the first byte of a frame and selects the buffer. Byte i of the frame is stored at offset i. A read with address bit 12 = 0, bit 11 = buffer, bits 10:0 = offset returns that byte zero-extended to 32 bits.
- R4: If bit 0 of the selected buffer is 1 when the first byte arrives, the whole frame is discarded. No byte of that buffer changes and its control word keeps its value.
- R5: A frame longer than `CAP_BYTES` (2048) bytes is rejected and leaves bit 0 clear. A frame of exactly 2048 bytes is accepted, with its last byte at offset 2047.
- R6: When a frame is accepted, bit 0 of its buffer's control word is set by the clock edge that takes the last byte. It reads 1 in the cycle after that edge.
- R7: When bit 3 of that control word is 1 after that edge, the buffer's `irq` bit is high for exactly one cycle, the cycle after the next edge. When bit 3 is 0, no pulse occurs.
- R8: A write with address bit 12 = 1 stores all 32 bits of `reg_wdata` into the control word of the buffer chosen by bit 11; bits 10:0 are ignored. Writing bit 0 as 0 reopens the buffer.
- R9: When a control-word write and a frame completion for the same buffer fall on the same edge, the stored value is the written value with bit 0 forced to 1, and the interrupt follows R7 using the written bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe of the incoming frame |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_buf_sel | input | 1 | Target buffer, sampled with the first byte |
| station_mac | input | 48 | Station address for the unicast match |
| reg_addr | input | 13 | Register address: space, buffer, offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 2 | One-cycle interrupt pulse per buffer |

## Verification
The same buffer's control word can be written by software and set by a frame completion on the same clock edge. The bench provokes this by driving a control-word write of the interrupt-enable value in the same cycle as the last byte of an accepted frame. It then expects a read-back of that value with bit 0 also set, plus a single interrupt pulse on that buffer. A scoreboard queue matches every interrupt pulse against the completions the driver announced, so a lost or extra pulse in this collision is caught.

// File: rtl/eth_rxb_pkg.sv
package eth_rxb_pkg;

    localparam int NBUF      = 2;
    localparam int CTRL_W    = 32;
    localparam int DST_BYTES = 6;

    // control word bit positions
    localparam int STAT_BIT = 0;
    localparam int AUX_BIT  = 1;
    localparam int IE_BIT   = 3;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_STORE = 2'd1,
        RX_SKIP  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic       last;
        logic [7:0] data;
    } rx_beat_t;

    typedef struct packed {
        logic ctrl_space;
        logic buf_idx;
    } reg_sel_t;

    // destination byte idx of the station address, most significant first
    function automatic logic [7:0] mac_byte(input logic [47:0] mac, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = mac[47:40];
            3'd1:    b = mac[39:32];
            3'd2:    b = mac[31:24];
            3'd3:    b = mac[23:16];
            3'd4:    b = mac[15:8];
            default: b = mac[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/eth_rxb_dst_filter.sv
module eth_rxb_dst_filter
    import eth_rxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_en,
    input  logic        first,
    input  logic [7:0]  data,
    input  logic [47:0] station_mac,
    output logic        pass_now
);

    logic [2:0] idx_q;
    logic       mcast_q;
    logic       eq_q;

    logic [2:0] cur_idx;
    logic       cur_mcast;
    logic       eq_prev;
    logic       byte_eq;
    logic       eq_inc;

    // pass_now includes the byte currently presented
    always_comb begin
        cur_idx   = first ? 3'd0 : idx_q;
        cur_mcast = first ? data[7] : mcast_q;
        eq_prev   = first ? 1'b1 : eq_q;
        byte_eq   = (cur_idx < 3'(DST_BYTES)) ? (data == mac_byte(station_mac, cur_idx)) : 1'b1;
        eq_inc    = eq_prev & byte_eq;
        pass_now  = cur_mcast | (eq_inc & (cur_idx >= 3'(DST_BYTES - 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= 3'd0;
            mcast_q <= 1'b0;
            eq_q    <= 1'b0;
        end else if (byte_en) begin
            mcast_q <= cur_mcast;
            eq_q    <= eq_inc;
            if (cur_idx < 3'(DST_BYTES)) begin
                idx_q <= cur_idx + 3'd1;
            end
        end
    end

endmodule

// File: rtl/eth_rxb_ram.sv
module eth_rxb_ram #(
    parameter int NBUF  = 2,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] wr_buf,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [BW-1:0] rd_buf,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] rd_bank [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wr_buf == BW'(g))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_bank[g] = mem[rd_addr];
    end

    assign rd_data = rd_bank[rd_buf];

endmodule

// File: rtl/eth_rxb_ctrl_regs.sv
module eth_rxb_ctrl_regs
    import eth_rxb_pkg::*;
#(
    parameter int NB  = NBUF,
    parameter int W   = CTRL_W,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BW-1:0]        wr_buf,
    input  logic [W-1:0]         wr_data,
    input  logic [NB-1:0]        set_stat,
    output logic [NB-1:0][W-1:0] ctrl_o,
    output logic [NB-1:0]        irq_o
);

    logic [NB-1:0] done_q;

    for (genvar g = 0; g < NB; g++) begin : g_reg
        logic [W-1:0] word_q;
        logic [W-1:0] word_nxt;

        // completion wins over a same-edge write for the held flag
        always_comb begin
            word_nxt = (wr_en && (wr_buf == BW'(g))) ? wr_data : word_q;
            if (set_stat[g]) begin
                word_nxt[STAT_BIT] = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q    <= '0;
                done_q[g] <= 1'b0;
                irq_o[g]  <= 1'b0;
            end else begin
                word_q    <= word_nxt;
                done_q[g] <= set_stat[g];
                irq_o[g]  <= done_q[g] & word_q[IE_BIT];
            end
        end

        assign ctrl_o[g] = word_q;
    end

endmodule

// File: rtl/eth_rx_buffer_ctrl.sv
module eth_rx_buffer_ctrl
    import eth_rxb_pkg::*;
#(
    parameter int CAP_BYTES = 2048,
    localparam int OFS_W    = $clog2(CAP_BYTES),
    localparam int ADDR_W   = OFS_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_buf_sel,
    input  logic [47:0]       station_mac,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic [NBUF-1:0]   irq
);

    localparam int CNT_W = $clog2(CAP_BYTES + 1);
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP_BYTES);

    rx_state_e state_q;
    logic      buf_q;
    logic [CNT_W-1:0] cnt_q;
    logic      ovf_q;

    rx_beat_t  beat;
    logic      act_buf;
    logic      buf_busy;
    logic      store_byte;
    logic [CNT_W-1:0] cur_cnt;
    logic      in_cap;
    logic      ovf_now;
    logic      ram_we;
    logic      pass_now;
    logic [NBUF-1:0] done_w;

    logic [NBUF-1:0][CTRL_W-1:0] ctrl_w;
    reg_sel_t  rsel;
    logic      ctrl_wr;
    logic      wr_buf_w;
    logic [7:0] ram_rd;

    // ---------------- frame intake ----------------
    always_comb begin
        beat.valid = rx_valid;
        beat.first = rx_valid && (state_q == RX_IDLE);
        beat.last  = rx_last;
        beat.data  = rx_data;

        act_buf    = beat.first ? rx_buf_sel : buf_q;
        buf_busy   = ctrl_w[act_buf][STAT_BIT];
        store_byte = beat.valid && ((beat.first && !buf_busy) || (state_q == RX_STORE));
        cur_cnt    = beat.first ? '0 : cnt_q;
        in_cap     = cur_cnt < CAP_C;
        ovf_now    = (beat.first ? 1'b0 : ovf_q) | !in_cap;
        ram_we     = store_byte && in_cap;

        done_w = '0;
        if (store_byte && beat.last && pass_now && !ovf_now) begin
            done_w[act_buf] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            buf_q   <= 1'b0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else if (beat.valid) begin
            case (state_q)
                RX_IDLE: begin
                    buf_q <= rx_buf_sel;
                    cnt_q <= CNT_W'(1);
                    ovf_q <= 1'b0;
                    if (!beat.last) begin
                        state_q <= buf_busy ? RX_SKIP : RX_STORE;
                    end
                end
                RX_STORE: begin
                    if (in_cap) begin
                        cnt_q <= cur_cnt + CNT_W'(1);
                    end
                    ovf_q <= ovf_now;
                    if (beat.last) begin
                        state_q <= RX_IDLE;
                    end
                end
                RX_SKIP: begin
                    if (beat.last) begin
                        state_q <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    eth_rxb_dst_filter u_filter (
        .clk         (clk),
        .rst         (rst),
        .byte_en     (store_byte),
        .first       (beat.first),
        .data        (beat.data),
        .station_mac (station_mac),
        .pass_now    (pass_now)
    );

    // ---------------- register port ----------------
    assign rsel     = reg_addr[ADDR_W-1 -: 2];
    assign ctrl_wr  = reg_we && rsel.ctrl_space;
    assign wr_buf_w = rsel.buf_idx;

    eth_rxb_ram #(
        .NBUF  (NBUF),
        .DEPTH (CAP_BYTES)
    ) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .wr_buf  (act_buf),
        .wr_addr (cur_cnt[OFS_W-1:0]),
        .wr_data (beat.data),
        .rd_buf  (rsel.buf_idx),
        .rd_addr (reg_addr[OFS_W-1:0]),
        .rd_data (ram_rd)
    );

    eth_rxb_ctrl_regs #(
        .NB (NBUF),
        .W  (CTRL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr),
        .wr_buf   (wr_buf_w),
        .wr_data  (reg_wdata),
        .set_stat (done_w),
        .ctrl_o   (ctrl_w),
        .irq_o    (irq)
    );

    always_comb begin
        if (rsel.ctrl_space) begin
            reg_rdata = ctrl_w[rsel.buf_idx];
        end else begin
            reg_rdata = {{(CTRL_W - 8){1'b0}}, ram_rd};
        end
    end

endmodule

// File: rtl/eth_rx_buffer_ctrl_chk.sv
module eth_rx_buffer_ctrl_chk
    import eth_rxb_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NBUF-1:0]             irq,
    input logic [NBUF-1:0][CTRL_W-1:0] ctrl,
    input logic [NBUF-1:0]             done,
    input logic                        ram_we,
    input rx_state_e                   state,
    input logic                        wr_en,
    input logic                        wr_buf,
    input logic [CTRL_W-1:0]           wdata
);

    // R1: registers come out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == '0 && irq == '0));

    // R4: a discarded frame never reaches the buffer storage
    a_r4_skip_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SKIP) |-> !ram_we);

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        // R6: completion sets the held flag on the next edge
        a_r6_status_set: assert property (@(posedge clk) disable iff (rst)
            done[g] |=> ctrl[g][STAT_BIT]);

        // R7: pulse lasts one cycle
        a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
            irq[g] |=> !irq[g]);

        // R7: pulse only with enable set and two edges after completion
        a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> ($past(ctrl[g][IE_BIT]) && $past(done[g], 2)));

        // R9: same-edge write and completion merge
        a_r9_merge: assert property (@(posedge clk) disable iff (rst)
            (done[g] && wr_en && (wr_buf == 1'(g))) |=> (ctrl[g] == ($past(wdata) | 32'h1)));
    end

endmodule

bind eth_rx_buffer_ctrl eth_rx_buffer_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq),
    .ctrl   (ctrl_w),
    .done   (done_w),
    .ram_we (ram_we),
    .state  (state_q),
    .wr_en  (ctrl_wr),
    .wr_buf (wr_buf_w),
    .wdata  (reg_wdata)
);

// File: tb/eth_rx_buffer_ctrl_bench.sv
module eth_rx_buffer_ctrl_bench;

    localparam int CAP = 2048;
    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_buf_sel = 1'b0;
    logic [12:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0] irq_exp [$];

    always #2 clk = ~clk;

    eth_rx_buffer_ctrl u_eth_rx_buffer_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_buf_sel  (rx_buf_sel),
        .station_mac (MAC),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] ctrl_addr(input logic b);
        return {1'b1, b, 11'h000};
    endfunction

    function automatic logic [12:0] data_addr(input logic b, input int ofs);
        return {1'b0, b, 11'(ofs)};
    endfunction

    function automatic logic [7:0] frame_byte(input logic [47:0] dst, input int i, input int seed);
        if (i < 6) return dst[8*(5-i) +: 8];
        return 8'((seed + i * 13) & 255);
    endfunction

    task automatic rd_now(input logic [12:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // driver: ends at the negedge after the edge that takes the last byte
    task automatic send_frame(input logic b, input int len, input logic [47:0] dst, input int seed,
                              input bit collide, input logic [31:0] cdata);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid   = 1'b1;
            rx_buf_sel = b;
            rx_data    = frame_byte(dst, i, seed);
            rx_last    = (i == len - 1);
            if (collide && (i == len - 1)) begin
                reg_addr  = ctrl_addr(b);
                reg_wdata = cdata;
                reg_we    = 1'b1;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        reg_we   = 1'b0;
    endtask

    // checks control word now, then the interrupt over the next two cycles
    task automatic after_frame(input logic b, input logic [31:0] exp_ctrl, input bit exp_irq, input string tag);
        logic [31:0] d;
        if (exp_irq) irq_exp.push_back(b ? 2'b10 : 2'b01);
        rd_now(ctrl_addr(b), d);
        check(d == exp_ctrl, {tag, " control word"}, d, exp_ctrl);
        check(irq == 2'b00, "R7 no pulse in first cycle", {30'b0, irq}, 32'h0);
        @(negedge clk);
        check(irq[b] == exp_irq, {tag, " R7 pulse cycle"}, {31'b0, irq[b]}, {31'b0, exp_irq});
        @(negedge clk);
        check(irq == 2'b00, "R7 pulse width", {30'b0, irq}, 32'h0);
    endtask

    // monitor: every pulse must match an announced completion
    always @(negedge clk) begin
        if (!rst && irq !== 2'b00) begin
            if (irq_exp.size() == 0) begin
                check(1'b0, "R7 unexpected irq", {30'b0, irq}, 32'h0);
            end else begin
                logic [1:0] e;
                e = irq_exp.pop_front();
                check(irq == e, "R7 scoreboard irq", {30'b0, irq}, {30'b0, e});
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [47:0] near;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_now(ctrl_addr(1'b0), d);
        check(d == 32'h0, "R1 ctrl0 after reset", d, 32'h0);
        rd_now(ctrl_addr(1'b1), d);
        check(d == 32'h0, "R1 ctrl1 after reset", d, 32'h0);
        check(irq == 2'b00, "R1 irq after reset", {30'b0, irq}, 32'h0);

        // R2/R3/R6 unicast match into buffer 0, interrupt disabled
        send_frame(1'b0, 64, MAC, 1, 1'b0, 32'h0);
        after_frame(1'b0, 32'h1, 1'b0, "R6 unicast accept");
        rd_now(data_addr(1'b0, 0), d);
        check(d == 32'h02, "R3 byte 0", d, 32'h02);
        rd_now(data_addr(1'b0, 5), d);
        check(d == 32'h55, "R3 byte 5", d, 32'h55);
        rd_now(data_addr(1'b0, 63), d);
        check(d == {24'b0, frame_byte(MAC, 63, 1)}, "R3 byte 63", d, {24'b0, frame_byte(MAC, 63, 1)});
        rd_now(ctrl_addr(1'b1), d);
        check(d == 32'h0, "R3 other buffer untouched", d, 32'h0);

        // R4 buffer 0 closed: frame discarded whole
        send_frame(1'b0, 64, 48'h81_00_00_00_00_07, 9, 1'b0, 32'h0);
        after_frame(1'b0, 32'h1, 1'b0, "R4 busy drop");
        rd_now(data_addr(1'b0, 0), d);
        check(d == 32'h02, "R4 byte 0 kept", d, 32'h02);
        rd_now(data_addr(1'b0, 63), d);
        check(d == {24'b0, frame_byte(MAC, 63, 1)}, "R4 byte 63 kept", d, {24'b0, frame_byte(MAC, 63, 1)});

        // R8 write stores full word, lower address bits ignored
        wr(ctrl_addr(1'b0) | 13'h01C, 32'hA5A0_000A);
        rd_now(ctrl_addr(1'b0), d);
        check(d == 32'hA5A0_000A, "R8 ctrl0 stored", d, 32'hA5A0_000A);
        wr(ctrl_addr(1'b0), 32'h8);

        // R2/R7 group frame with interrupt enabled
        send_frame(1'b0, 20, 48'h81_00_00_00_00_01, 3, 1'b0, 32'h0);
        after_frame(1'b0, 32'h9, 1'b1, "R7 group accept");
        rd_now(data_addr(1'b0, 0), d);
        check(d == 32'h81, "R3 group byte 0", d, 32'h81);

        // R2 unicast mismatch in the final address byte
        near = MAC ^ 48'h1;
        send_frame(1'b1, 30, near, 4, 1'b0, 32'h0);
        after_frame(1'b1, 32'h0, 1'b0, "R2 mismatch drop");

        // R2 short frame: first five address bytes only
        send_frame(1'b1, 5, MAC, 5, 1'b0, 32'h0);
        after_frame(1'b1, 32'h0, 1'b0, "R2 short frame drop");

        // R5 oversize then exact capacity
        send_frame(1'b1, CAP + 1, MAC, 6, 1'b0, 32'h0);
        after_frame(1'b1, 32'h0, 1'b0, "R5 oversize reject");
        send_frame(1'b1, CAP, MAC, 7, 1'b0, 32'h0);
        after_frame(1'b1, 32'h1, 1'b0, "R5 exact capacity");
        rd_now(data_addr(1'b1, CAP - 1), d);
        check(d == {24'b0, frame_byte(MAC, CAP - 1, 7)}, "R5 last byte", d, {24'b0, frame_byte(MAC, CAP - 1, 7)});

        // R8 reopen, R9 same-edge write and completion
        wr(ctrl_addr(1'b1), 32'h0);
        rd_now(ctrl_addr(1'b1), d);
        check(d == 32'h0, "R8 reopen ctrl1", d, 32'h0);
        send_frame(1'b1, 16, 48'h83_00_00_00_00_02, 8, 1'b1, 32'h8);
        after_frame(1'b1, 32'h9, 1'b1, "R9 collision");

        check(irq_exp.size() == 0, "R7 scoreboard drained", irq_exp.size(), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule